// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block produces the serial clock that an SPI master shifts data with. It runs from the block input clock. One configuration bit chooses whether the count is driven by every input clock cycle or by every sixteenth one. A 4-bit modulus then sets a prescaler. The serial clock period is 4 × (modulus + 1) source ticks, with equal high and low phases. The overall input-to-serial-clock ratio therefore runs from 4 up to 1024.

Alongside the clock, the block emits two single-cycle strobes for the shift engine. One marks the edge where the serial clock leaves its idle level (leading). The other marks the edge where it returns to idle (trailing). An enable input starts and stops the generator. While it is low, the clock rests at the level chosen by an idle-polarity input. The modulus, the divide-by-16 choice and the idle polarity are captured only while the generator is disabled. On each enable, the counters start from zero.

Top module: `spi_brg`

## Requirements
- R1: With `div16_i` = 0 the prescaler advances on every input clock cycle; with `div16_i` = 1 it advances once per 16 input clock cycles.
- R2: Each half-period of `sclk_o` lasts H = 2 × (PM + 1) × S input cycles, where S = 1 or 16 per R1. For PM = 3 and `div16_i` = 1, a full period is 256 input cycles.
- R3: The high and low phases of `sclk_o` are equal in length (50% duty cycle) for every PM and source setting.
- R4: `lead_o` is high for exactly one cycle, in the cycle right after `sclk_o` moves away from its idle level.
- R5: `trail_o` is high for exactly one cycle, in the cycle right after `sclk_o` returns to its idle level. `lead_o` and `trail_o` are never high together.
- R6: One cycle after a clock edge that samples `en_i` low, `sclk_o` equals the `cpol_i` sampled at that edge (0 = idle low, 1 = idle high). Both strobes are low, and the counters are cleared.
- R7: `pm_i`, `div16_i` and `cpol_i` are captured only at edges where `en_i` is low. Changes while `en_i` is high have no effect on `sclk_o` or the strobes.
- R8: After enabling, the first `sclk_o` transition follows the H-th edge that samples `en_i` high. This holds even when the previous enabled run was cut off mid-period.
- R9: While `rst_n` is low, `sclk_o`, `lead_o` and `trail_o` are 0. Reset assertion is asynchronous and release is synchronised over two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Generator enable |
| div16_i | input | 1 | Source select: 0 input clock, 1 input clock / 16 |
| pm_i | input | PM_W | Prescale modulus PM |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock, 50% duty cycle |
| lead_o | output | 1 | One-cycle strobe after a leading edge |
| trail_o | output | 1 | One-cycle strobe after a trailing edge |

## Verification
The edge counter, the prescaler and the output register put each serial clock transition in the cycle after the c-th enabled edge, where c is a multiple of H. The matching strobe appears in that same cycle. The bench counts enabled edges from the first one that samples `en_i` high and samples all outputs on the falling clock edge. It compares them each cycle against cpol ^ ((c / H) mod 2), with the strobes expected only where c mod H = 0. A disable is due one edge after `en_i` falls. The bench checks for it at the next falling edge, while the configuration inputs are held inverted to show that they are ignored.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;
  localparam int BRG_PM_W_DEF   = 4;
  localparam int BRG_PREDIV_DEF = 16;

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } brg_edge_e;
endpackage

// File: rtl/spi_brg_cfg.sv
module spi_brg_cfg #(
  parameter int PM_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            div16_i,
  input  logic [PM_W-1:0] pm_i,
  input  logic            cpol_i,
  output logic            div16_q,
  output logic [PM_W-1:0] pm_q,
  output logic            cpol_q
);
  logic            load;
  logic            div16_d;
  logic [PM_W-1:0] pm_d;
  logic            cpol_d;

  always_comb begin
    load    = !en_i;
    div16_d = load ? div16_i : div16_q;
    pm_d    = load ? pm_i    : pm_q;
    cpol_d  = load ? cpol_i  : cpol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div16_q <= 1'b0;
      pm_q    <= '0;
      cpol_q  <= 1'b0;
    end else begin
      div16_q <= div16_d;
      pm_q    <= pm_d;
      cpol_q  <= cpol_d;
    end
  end

  // R7: captured settings hold while enabled
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> ($stable(pm_q) && $stable(div16_q) && $stable(cpol_q)));
endmodule

// File: rtl/spi_brg_prediv.sv
module spi_brg_prediv #(
  parameter int PRE_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic div16_i,
  output logic tick_o
);
  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int PRE_W = $clog2(PRE_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
      logic [PRE_W-1:0] cnt_q, cnt_d;
      logic             at_last;

      always_comb begin
        at_last = (cnt_q == PRE_LAST);
        if (!run_i || !div16_i) cnt_d = '0;
        else if (at_last)       cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
        tick_o = run_i && (!div16_i || at_last);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R1: divided source never ticks on back-to-back cycles
      a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div16_i && run_i) |=> !tick_o);
    end else begin : g_nodiv
      always_comb tick_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/spi_brg_halfcnt.sv
module spi_brg_halfcnt #(
  parameter int HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [HALF_W-1:0] last_i,
  output logic              wrap_o
);
  logic [HALF_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap_o = run_i && tick_i && (cnt_q == last_i);
    if (!run_i)      cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: count restarts from zero after a disable
  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
  // R2: the counter never passes its terminal value
  a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= last_i));
endmodule

// File: rtl/spi_brg.sv
module spi_brg #(
  parameter int PM_W    = spi_brg_pkg::BRG_PM_W_DEF,
  parameter int PRE_DIV = spi_brg_pkg::BRG_PREDIV_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            div16_i,
  input  logic [PM_W-1:0] pm_i,
  input  logic            cpol_i,
  output logic            sclk_o,
  output logic            lead_o,
  output logic            trail_o
);
  import spi_brg_pkg::*;

  localparam int HALF_W = PM_W + 1;

  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic              div16_q, cpol_q;
  logic [PM_W-1:0]   pm_q;
  logic              tick, wrap;
  logic [HALF_W-1:0] half_last;
  logic              sclk_q, sclk_d;
  brg_edge_e         edge_q, edge_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  spi_brg_cfg #(.PM_W(PM_W)) i_cfg (
    .clk(clk), .rst_n(rst_int_n), .en_i(en_i),
    .div16_i(div16_i), .pm_i(pm_i), .cpol_i(cpol_i),
    .div16_q(div16_q), .pm_q(pm_q), .cpol_q(cpol_q)
  );

  spi_brg_prediv #(.PRE_DIV(PRE_DIV)) i_prediv (
    .clk(clk), .rst_n(rst_int_n), .run_i(en_i),
    .div16_i(div16_q), .tick_o(tick)
  );

  assign half_last = {pm_q, 1'b1};

  spi_brg_halfcnt #(.HALF_W(HALF_W)) i_halfcnt (
    .clk(clk), .rst_n(rst_int_n), .run_i(en_i),
    .tick_i(tick), .last_i(half_last), .wrap_o(wrap)
  );

  always_comb begin
    sclk_d = sclk_q;
    edge_d = EDGE_NONE;
    if (!en_i) begin
      sclk_d = cpol_i;
    end else if (wrap) begin
      sclk_d = !sclk_q;
      edge_d = (sclk_q == cpol_q) ? EDGE_LEAD : EDGE_TRAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sclk_q <= 1'b0;
      edge_q <= EDGE_NONE;
    end else begin
      sclk_q <= sclk_d;
      edge_q <= edge_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign lead_o  = (edge_q == EDGE_LEAD);
  assign trail_o = (edge_q == EDGE_TRAIL);

  // R5: strobes are mutually exclusive
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(lead_o && trail_o));
  // R4: a leading strobe sees the clock away from idle
  a_r4_lead_active: assert property (@(posedge clk) disable iff (!rst_int_n)
    lead_o |-> (sclk_o != cpol_q));
  // R5: a trailing strobe sees the clock at idle
  a_r5_trail_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    trail_o |-> (sclk_o == cpol_q));
  // R4: while enabled, the clock moves exactly when a strobe fires
  a_r4_move_strobe: assert property (@(posedge clk) disable iff (!rst_int_n)
    en_i |=> (!$stable(sclk_o) == (lead_o || trail_o)));
  // R6: disabled output parks at the idle level
  a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_i |=> ((sclk_o == $past(cpol_i)) && !lead_o && !trail_o));
endmodule

// File: tb/test_spi_brg.sv
module test_spi_brg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic       div16_i = 1'b0;
  logic [3:0] pm_i = 4'd0;
  logic       cpol_i = 1'b0;
  logic       sclk_o, lead_o, trail_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = !clk;

  spi_brg i_spi_brg (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .div16_i(div16_i),
    .pm_i(pm_i), .cpol_i(cpol_i),
    .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // run c = 1..ncyc enabled edges and compare every cycle
  task automatic run_enabled(input int h, input logic pol, input int ncyc, input string req);
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      chk({req, " sclk"}, int'(sclk_o), int'(pol ^ (((c / h) % 2) == 1)));
      chk({req, " lead"}, int'(lead_o), int'((c % h == 0) && ((c / h) % 2 == 1)));
      chk({req, " trail"}, int'(trail_o), int'((c % h == 0) && ((c / h) % 2 == 0)));
    end
  endtask

  initial begin
    for (int w = 0; w < 200000; w++) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state
    cpol_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 sclk in reset", int'(sclk_o), 0);
    chk("R9 lead in reset", int'(lead_o), 0);
    chk("R9 trail in reset", int'(trail_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle after release", int'(sclk_o), 1);

    // R1 R2 R3 R4 R5 R6 R7: sweep every modulus and source
    for (int pm = 0; pm < 16; pm++) begin
      for (int d = 0; d < 2; d++) begin
        automatic logic pol = logic'(pm[0] ^ d[0]);
        automatic int   h = 2 * (pm + 1) * ((d == 1) ? 16 : 1);
        en_i = 1'b0;
        pm_i = 4'(pm);
        div16_i = d[0];
        cpol_i = pol;
        @(negedge clk);
        chk("R6 idle level before enable", int'(sclk_o), int'(pol));
        en_i = 1'b1;
        pm_i = ~4'(pm);      // R7: ignored while enabled
        div16_i = !d[0];
        cpol_i = !pol;
        run_enabled(h, pol, 4 * h, "R2 R3 R4 R5 R7 sweep");
        en_i = 1'b0;
        @(negedge clk);
        chk("R6 disable to cpol_i", int'(sclk_o), int'(!pol));
        chk("R6 no lead when disabled", int'(lead_o), 0);
        chk("R6 no trail when disabled", int'(trail_o), 0);
      end
    end

    // R2: PM = 3 with divide-by-16 gives a 256-cycle period
    en_i = 1'b0; pm_i = 4'd3; div16_i = 1'b1; cpol_i = 1'b0;
    @(negedge clk);
    en_i = 1'b1;
    run_enabled(128, 1'b0, 256, "R2 ratio 256");

    // R8: cut off mid-period, re-enable, first half-period is full
    en_i = 1'b0; pm_i = 4'd1; div16_i = 1'b0; cpol_i = 1'b0;
    @(negedge clk);
    en_i = 1'b1;
    run_enabled(4, 1'b0, 6, "R8 first run");
    en_i = 1'b0;
    @(negedge clk);
    chk("R8 parked", int'(sclk_o), 0);
    en_i = 1'b1;
    run_enabled(4, 1'b0, 8, "R8 restart");
    en_i = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule